// File: doc/BRIEF.md
# Access-Protected Paged Memory Controller

This block sits in front of a 1024-byte storage array and decides, for every byte-level request, whether it may proceed. The array is divided into eight 128-byte blocks, and each block holds eight 16-byte pages. A separate 16-byte settings page, reached with its own select input, holds read and write lock bits. For blocks 1 to 7 the locks apply to the whole block. Block 0 has a lock for the whole block and also a lock for each of its pages. A global write-protect input overrides the settings and stops every write to the main array.

A request is either a random read, a read at the running pointer, or a write of 1 to 16 bytes. A write burst supplies all its bytes in parallel, and its addresses wrap inside one aligned 16-byte page. Each request the block accepts produces one response a cycle later. The response carries the read byte and a denial flag, and a blocked or write response carries 0xFF. A successful write starts a self-timed busy interval. The block ignores requests for the whole of that interval.

Top module: `prot_mem_ctrl`

## Requirements
- R1: After reset every main-array byte and every settings byte reads 0xFF, `rsp_valid_o` and `busy_o` are low, and the read pointer is 0.
- R2: A request taken while `busy_o` is low (`cmd_i`=00 is a random read at `addr_i`) gives exactly one response: `rsp_valid_o` is high for one cycle, in the cycle after the request.
- R3: `cmd_i`=01 reads the main byte at the read pointer and ignores `addr_i` and `cfg_i`. After any main-array read, whether granted or denied, the pointer holds that read's address plus one, modulo 1024.
- R4: `cmd_i`=1x writes `len_i`+1 bytes. Byte k is taken from `wdata_i[8k+7:8k]` and goes to page offset (`addr_i[3:0]`+k) mod 16 of the page that `addr_i` selects. No byte outside that page changes.
- R5: With `cfg_i`=1, reads (`cmd_i`=00) and burst writes use settings byte `addr_i[3:0]`. Settings accesses are never denied and ignore `wp_i`.
- R6: Settings byte 0 bit b grants reads of block b (`addr_i[9:7]`), and byte 1 bit b grants writes to it. A bit value of 0 locks the access.
- R7: An access to block 0 also needs the page bit for page p (`addr_i[6:4]`): byte 2 bit p for reads, byte 3 bit p for writes.
- R8: Read and write locks act independently. A write lock does not stop reads, and a read lock does not stop writes.
- R9: While `wp_i` is high, every main-array write is denied.
- R10: A denied request sets `deny_o` with its response and returns 0xFF. A denied write leaves the array unchanged. Every write response returns 0xFF.
- R11: An accepted, non-denied write (main or settings) holds `busy_o` high for exactly BUSY_CYCLES cycles, starting with its response cycle. Reads and denied writes do not raise `busy_o`.
- R12: A request made while `busy_o` is high gets no response and changes neither memory nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| cmd_i | input | 2 | 00 random read, 01 pointer read, 1x burst write |
| cfg_i | input | 1 | Selects the settings page instead of the main array |
| wp_i | input | 1 | Global write protect for the main array |
| addr_i | input | 10 | Byte address (low 4 bits give the offset within the settings page) |
| len_i | input | 4 | Burst byte count minus one |
| wdata_i | input | 128 | Burst bytes; byte k in bits 8k+7:8k |
| rsp_valid_o | output | 1 | Response strobe |
| rdata_o | output | 8 | Read byte, or 0xFF on a write or a denial |
| deny_o | output | 1 | Request was blocked by protection |
| busy_o | output | 1 | Write busy interval in progress |

## Verification
The bound checker checks these on every cycle: each accepted request gets one response, and nothing answers an idle or busy cycle. A denial always carries 0xFF and never starts the busy interval. The write-protect input always denies main writes, and settings accesses are never denied. Some behaviours need the bench scenarios because they depend on stored contents: burst wrap inside a page, the pointer wrapping from 1023 to 0, mixed block and page locks in block 0, a denied write leaving old data in place, the exact length of the busy interval, and a write sent during busy having no effect.

// File: rtl/prot_mem_pkg.sv
package prot_mem_pkg;
  localparam int unsigned MEM_BYTES  = 1024;
  localparam int unsigned BLK_BYTES  = 128;
  localparam int unsigned PAGE_BYTES = 16;

  // settings page byte roles
  localparam int unsigned SET_RD_BLK = 0;
  localparam int unsigned SET_WR_BLK = 1;
  localparam int unsigned SET_RD_PG  = 2;
  localparam int unsigned SET_WR_PG  = 3;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_NEXT  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_WRALT = 2'b11
  } cmd_e;
endpackage

// File: rtl/prot_mem_array.sv
module prot_mem_array #(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [OW-1:0]           len_i,
  input  logic [PAGE_BYTES*8-1:0] wdata_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [7:0]              rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (OW'(k) <= len_i)
          mem_q[{waddr_i[AW-1:OW], OW'(waddr_i[OW-1:0] + OW'(k))}] <= wdata_i[k*8 +: 8];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/prot_mem_guard.sv
module prot_mem_guard
  import prot_mem_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned N_BLK      = 8,
  parameter int unsigned N_PG       = 8,
  localparam int unsigned OW = $clog2(PAGE_BYTES),
  localparam int unsigned BW = $clog2(N_BLK),
  localparam int unsigned PW = $clog2(N_PG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_we_i,
  input  logic [OW-1:0]           set_off_i,
  input  logic [OW-1:0]           len_i,
  input  logic [PAGE_BYTES*8-1:0] wdata_i,
  output logic [7:0]              set_rdata_o,
  input  logic [BW-1:0]           blk_i,
  input  logic [PW-1:0]           pg_i,
  input  logic                    wp_i,
  output logic                    rd_ok_o,
  output logic                    wr_ok_o
);
  logic [7:0] set_q [PAGE_BYTES];
  logic       blk0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) set_q[i] <= '1;
    end else if (set_we_i) begin
      for (int k = 0; k < PAGE_BYTES; k++) begin
        if (OW'(k) <= len_i) set_q[OW'(set_off_i + OW'(k))] <= wdata_i[k*8 +: 8];
      end
    end
  end

  assign set_rdata_o = set_q[set_off_i];
  assign blk0        = (blk_i == '0);

  // block 0 also needs its page grant
  assign rd_ok_o = set_q[SET_RD_BLK][blk_i] && (!blk0 || set_q[SET_RD_PG][pg_i]);
  assign wr_ok_o = !wp_i && set_q[SET_WR_BLK][blk_i] && (!blk0 || set_q[SET_WR_PG][pg_i]);
endmodule

// File: rtl/prot_mem_busy.sv
module prot_mem_busy #(
  parameter int unsigned CYCLES = 64,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/prot_mem_ctrl.sv
module prot_mem_ctrl
  import prot_mem_pkg::*;
#(
  parameter int unsigned DEPTH       = MEM_BYTES,
  parameter int unsigned BLK_SZ      = BLK_BYTES,
  parameter int unsigned PAGE_SZ     = PAGE_BYTES,
  parameter int unsigned BUSY_CYCLES = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(PAGE_SZ)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [1:0]           cmd_i,
  input  logic                 cfg_i,
  input  logic                 wp_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [OW-1:0]        len_i,
  input  logic [PAGE_SZ*8-1:0] wdata_i,
  output logic                 rsp_valid_o,
  output logic [7:0]           rdata_o,
  output logic                 deny_o,
  output logic                 busy_o
);
  localparam int unsigned N_BLK = DEPTH / BLK_SZ;
  localparam int unsigned N_PG  = BLK_SZ / PAGE_SZ;
  localparam int unsigned BW    = $clog2(N_BLK);
  localparam int unsigned PW    = $clog2(N_PG);

  cmd_e          cmd;
  logic          accept, is_wr, is_next, use_set, deny;
  logic          rd_ok, wr_ok, mem_we, set_we;
  logic [AW-1:0] ptr_q, addr_eff;
  logic [7:0]    mem_rdata, set_rdata, rd_byte;
  logic          rsp_q, deny_q;
  logic [7:0]    rdata_q;

  assign cmd      = cmd_e'(cmd_i);
  assign accept   = req_i && !busy_o;
  assign is_wr    = (cmd == CMD_WRITE) || (cmd == CMD_WRALT);
  assign is_next  = (cmd == CMD_NEXT);
  assign use_set  = cfg_i && !is_next;
  assign addr_eff = is_next ? ptr_q : addr_i;
  assign deny     = !use_set && (is_wr ? !wr_ok : !rd_ok);
  assign mem_we   = accept && is_wr && !use_set && !deny;
  assign set_we   = accept && is_wr && use_set;
  assign rd_byte  = use_set ? set_rdata : mem_rdata;

  prot_mem_array #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_SZ)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (addr_eff),
    .len_i   (len_i),
    .wdata_i (wdata_i),
    .raddr_i (addr_eff),
    .rdata_o (mem_rdata)
  );

  prot_mem_guard #(.PAGE_BYTES(PAGE_SZ), .N_BLK(N_BLK), .N_PG(N_PG)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_we_i    (set_we),
    .set_off_i   (addr_eff[OW-1:0]),
    .len_i       (len_i),
    .wdata_i     (wdata_i),
    .set_rdata_o (set_rdata),
    .blk_i       (addr_eff[AW-1 -: BW]),
    .pg_i        (addr_eff[OW +: PW]),
    .wp_i        (wp_i),
    .rd_ok_o     (rd_ok),
    .wr_ok_o     (wr_ok)
  );

  prot_mem_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mem_we || set_we),
    .busy_o  (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      deny_q  <= 1'b0;
      rdata_q <= '1;
      ptr_q   <= '0;
    end else begin
      rsp_q <= accept;
      if (accept) begin
        deny_q  <= deny;
        rdata_q <= (is_wr || deny) ? 8'hFF : rd_byte;
        // denied main reads still advance the pointer
        if (!is_wr && !use_set) ptr_q <= addr_eff + 1'b1;
      end
    end
  end

  assign rsp_valid_o = rsp_q;
  assign deny_o      = deny_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/prot_mem_ctrl_chk.sv
module prot_mem_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] cmd_i,
  input logic       cfg_i,
  input logic       wp_i,
  input logic       rsp_valid_o,
  input logic [7:0] rdata_o,
  input logic       deny_o,
  input logic       busy_o
);
  // R2
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> rsp_valid_o);

  // R12
  no_rsp_unaccepted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !busy_o) |=> !rsp_valid_o);

  // R10
  deny_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && deny_o) |-> (rdata_o == 8'hFF));

  // R9
  wp_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && cmd_i[1] && !cfg_i && wp_i) |=> deny_o);

  // R5
  set_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && cfg_i && cmd_i != 2'b01) |=> !deny_o);

  // R11
  deny_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && deny_o) |-> !busy_o);

  // R11
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !deny_o && $past(cmd_i[1])) |-> busy_o);

  // R11
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (rsp_valid_o && !deny_o));
endmodule

bind prot_mem_ctrl prot_mem_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .cmd_i       (cmd_i),
  .cfg_i       (cfg_i),
  .wp_i        (wp_i),
  .rsp_valid_o (rsp_valid_o),
  .rdata_o     (rdata_o),
  .deny_o      (deny_o),
  .busy_o      (busy_o)
);

// File: tb/prot_mem_ctrl_test.sv
module prot_mem_ctrl_test;
  localparam int BUSY = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [1:0]   cmd = 2'b00;
  logic         cfg = 1'b0;
  logic         wp = 1'b0;
  logic [9:0]   addr = '0;
  logic [3:0]   len = '0;
  logic [127:0] wd = '0;
  logic         rsp_valid_o, deny_o, busy_o;
  logic [7:0]   rdata_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       deny;
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] mdl [1024];
  logic [7:0] setm [16];
  logic [9:0] ptr_m = '0;

  always #2.5 clk = ~clk;

  prot_mem_ctrl #(.BUSY_CYCLES(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd), .cfg_i(cfg),
    .wp_i(wp), .addr_i(addr), .len_i(len), .wdata_i(wd),
    .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o), .deny_o(deny_o), .busy_o(busy_o)
  );

  // monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && rsp_valid_o) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected response: deny=%0b data=%02h expected none", deny_o, rdata_o);
      end else begin
        e = q.pop_front();
        if (deny_o !== e.deny || rdata_o !== e.data) begin
          errors++;
          $display("FAIL %s: deny=%0b data=%02h expected deny=%0b data=%02h",
                   e.tag, deny_o, rdata_o, e.deny, e.data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic issue(input logic [1:0] c, input logic s, input logic [9:0] a_in,
                       input logic [3:0] l, input logic [127:0] d, input logic w,
                       input string tag);
    exp_t e;
    logic [9:0] a;
    logic [2:0] b, p;
    logic wr, nx, us, dn;
    while (busy_o) @(negedge clk);
    wr = c[1];
    nx = !wr && c[0];
    us = s && !nx;
    a  = nx ? ptr_m : a_in;
    b  = a[9:7];
    p  = a[6:4];
    if (us)      dn = 1'b0;
    else if (wr) dn = w || !setm[1][b] || (b == 3'd0 && !setm[3][p]);
    else         dn = !setm[0][b] || (b == 3'd0 && !setm[2][p]);
    e.deny = dn;
    e.data = (wr || dn) ? 8'hFF : (us ? setm[a[3:0]] : mdl[a]);
    e.tag  = tag;
    if (wr && !dn) begin
      for (int k = 0; k < 16; k++) begin
        if (k <= int'(l)) begin
          if (us) setm[4'(a[3:0] + k)] = d[k*8 +: 8];
          else    mdl[{a[9:4], 4'(a[3:0] + k)}] = d[k*8 +: 8];
        end
      end
    end
    if (!wr && !us) ptr_m = a + 10'd1;
    q.push_back(e);
    req = 1'b1; cmd = c; cfg = s; addr = a_in; len = l; wd = d; wp = w;
    @(negedge clk);
    req = 1'b0; wp = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    issue(2'b00, 1'b0, a, 4'd0, '0, 1'b0, tag);
  endtask

  task automatic rd_next(input string tag);
    issue(2'b01, 1'b0, '0, 4'd0, '0, 1'b0, tag);
  endtask

  task automatic set_prot(input logic [7:0] rb, input logic [7:0] wb,
                          input logic [7:0] rp, input logic [7:0] wpg, input string tag);
    issue(2'b10, 1'b1, 10'd0, 4'd3, {96'd0, wpg, rp, wb, rb}, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] d;
    int n;
    for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < 16; i++) setm[i] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid_o == 1'b0 && busy_o == 1'b0, "R1 reset idle", {rsp_valid_o, busy_o}, 0);

    // R1 R2 erased array
    rd(10'd0, "R1 erased 0");
    rd(10'd513, "R2 random 513");
    rd(10'd1023, "R1 erased 1023");
    issue(2'b00, 1'b1, 10'd9, 4'd0, '0, 1'b0, "R1 settings erased");

    // R4 single byte
    issue(2'b10, 1'b0, 10'h105, 4'd0, 128'hA5, 1'b0, "R4 byte write");
    rd(10'h105, "R4 byte readback");
    rd(10'h104, "R4 neighbour untouched");

    // R4 full page, R3 pointer reads
    for (int k = 0; k < 16; k++) d[k*8 +: 8] = 8'(k * 3 + 1);
    issue(2'b10, 1'b0, 10'h200, 4'd15, d, 1'b0, "R4 page write");
    rd(10'h200, "R3 start");
    for (int k = 1; k < 16; k++) rd_next("R3 sequential");

    // R4 wrap inside page
    for (int k = 0; k < 16; k++) d[k*8 +: 8] = 8'h40 + 8'(k);
    issue(2'b11, 1'b0, 10'h31C, 4'd7, d, 1'b0, "R4 wrap write");
    rd(10'h310, "R4 wrap low");
    for (int k = 1; k < 16; k++) rd_next("R4 wrap page");
    rd(10'h320, "R4 next page untouched");

    // R3 pointer wrap 1023 -> 0
    issue(2'b10, 1'b0, 10'd0, 4'd0, 128'h3C, 1'b0, "R3 prep");
    rd(10'd1023, "R3 last");
    rd_next("R3 wrap to 0");

    // R6 R8 block read lock
    issue(2'b10, 1'b0, 10'h1A0, 4'd0, 128'h77, 1'b0, "R6 prep");
    set_prot(8'hF7, 8'hFF, 8'hFF, 8'hFF, "R5 set write");
    issue(2'b00, 1'b1, 10'd0, 4'd0, '0, 1'b0, "R5 settings readback");
    rd(10'h1A0, "R6 read locked");
    rd_next("R3 denied read advanced pointer");
    issue(2'b10, 1'b0, 10'h1A0, 4'd0, 128'h88, 1'b0, "R8 write allowed under read lock");
    set_prot(8'hFF, 8'hDF, 8'hFF, 8'hFF, "R5 set write");
    rd(10'h1A0, "R8 value written under read lock");

    // R10 R8 block write lock
    issue(2'b10, 1'b0, 10'h2A0, 4'd0, 128'h5A, 1'b0, "R10 write denied");
    rd(10'h2A0, "R10 array unchanged, R8 read open");
    issue(2'b10, 1'b0, 10'h1A0, 4'd0, 128'h99, 1'b0, "R6 other block writable");
    rd(10'h1A0, "R6 other block value");

    // R7 block 0 page locks
    set_prot(8'hFF, 8'hFF, 8'hFB, 8'hFD, "R5 set write");
    rd(10'h025, "R7 page read locked");
    rd(10'h035, "R7 page read open");
    issue(2'b10, 1'b0, 10'h012, 4'd0, 128'h11, 1'b0, "R7 page write locked");
    issue(2'b10, 1'b0, 10'h042, 4'd0, 128'h22, 1'b0, "R7 page write open");
    rd(10'h042, "R7 open page value");
    rd(10'h012, "R7 locked page unchanged");
    set_prot(8'hFE, 8'hFE, 8'hFF, 8'hFF, "R5 set write");
    rd(10'h035, "R7 whole block read lock");
    issue(2'b10, 1'b0, 10'h050, 4'd0, 128'h33, 1'b0, "R7 whole block write lock");
    rd(10'h090, "R7 block 1 open");
    set_prot(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 set write");
    rd(10'h050, "R7 block 0 unchanged");

    // R9 write protect
    issue(2'b10, 1'b0, 10'h300, 4'd0, 128'h44, 1'b1, "R9 wp denies");
    rd(10'h300, "R9 array unchanged");
    issue(2'b10, 1'b1, 10'd8, 4'd0, 128'h6B, 1'b1, "R5 settings ignore wp");
    issue(2'b00, 1'b1, 10'd8, 4'd0, '0, 1'b0, "R5 settings value");

    // R11 busy length
    while (busy_o) @(negedge clk);
    issue(2'b10, 1'b0, 10'h3F0, 4'd0, 128'hC3, 1'b0, "R11 busy write");
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    check(n == BUSY, "R11 busy length", n, BUSY);

    // R11 denied write leaves busy low
    issue(2'b10, 1'b0, 10'h3F1, 4'd0, 128'hC4, 1'b1, "R11 denied write");
    check(busy_o == 1'b0, "R11 no busy after denial", busy_o, 0);

    // R12 request during busy
    issue(2'b10, 1'b0, 10'h3F2, 4'd0, 128'hC5, 1'b0, "R12 start busy");
    req = 1'b1; cmd = 2'b10; cfg = 1'b0; addr = 10'h3F2; len = 4'd0; wd = 128'hEE;
    @(negedge clk);
    req = 1'b0;
    check(busy_o == 1'b1, "R12 still busy", busy_o, 1);
    rd(10'h3F2, "R12 refused write had no effect");
    rd_next("R12 pointer after refusal");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 all responses seen", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule